// File: doc/BRIEF.md
# Stereo Audio Serial Receiver

This block receives stereo audio from a three-wire serial link made of a bit clock, a frame-sync line and one data line. It runs as a slave, so the sender drives all three wires. Each channel word is a 16-bit two's complement sample sent most significant bit first. The block turns each pair of channel words into one parallel output pair, marked by a single-cycle strobe, for the DAC datapath that follows it.

The three serial wires are brought into the system clock domain through a synchronizer chain. Rising edges of the bit clock are detected in that domain, and the data line and frame sync are sampled at those edges. Two alignments can be selected while the block runs:

- **Justified:** the first bit of a word shares its bit period with the frame-sync change.
- **Delayed:** the first bit of a word comes one bit period after the frame-sync change.

A change of alignment waits for the next rising edge of frame sync, which is the start of a new stereo frame.

Top module: `stereo_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` and `out_err` are 0 and `out_left` and `out_right` are all zeros.
- R2: With `mode_i2s` = 0 (justified), the bit sampled on the bit-clock rising edge where a new frame-sync level is first seen is the MSB of a word. It is followed by the next 15 bits, MSB first.
- R3: With `mode_i2s` = 1 (delayed), the MSB of a word is the bit sampled on the bit-clock rising edge after the one where the new frame-sync level is first seen.
- R4: A word starting while frame sync is high is the left channel, and a word starting while it is low is the right channel. When a right word completes after a complete left word of the same frame, `out_valid` pulses for exactly one cycle with that pair on `out_left`/`out_right`. Both outputs hold their values until the next pulse.
- R5: Bits beyond the 16th within one frame-sync phase are ignored.
- R6: A word interrupted by a frame-sync change before its 16th bit is discarded. No pair is output for that frame, and `out_err` pulses for one cycle. `out_err` and `out_valid` are never high together.
- R7: A new `mode_i2s` value takes effect only at a rising edge of frame sync, so a frame in progress finishes in the old alignment. A word cut short by the alignment switch at that edge does not raise `out_err`.
- R8: The partial phase seen first after reset produces neither a pair nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i2s | input | 1 | Alignment request: 0 justified, 1 one-bit delayed |
| ser_bclk | input | 1 | Serial bit clock from the sender |
| ser_fs | input | 1 | Frame sync: high for left, low for right |
| ser_dat | input | 1 | Serial data, MSB first |
| out_valid | output | 1 | One-cycle strobe for a new stereo pair |
| out_left | output | 16 | Left sample of the latest pair |
| out_right | output | 16 | Right sample of the latest pair |
| out_err | output | 1 | One-cycle strobe for a discarded short word |

## Verification
Two events can land on the same bit-clock edge: an alignment switch and a word boundary that would otherwise count as a short word. The bench provokes this by sending a run of delayed-alignment frames and then requesting justified alignment. The last right word's final bit then falls exactly on the switching edge. The result passes only if no error strobe appears, that one pair is missing, and the justified pairs that follow decode correctly. Separately, short left and right phases check that a real truncation still raises the error.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;
  typedef enum logic {
    FMT_JUST  = 1'b0,
    FMT_DELAY = 1'b1
  } fmt_e;
endpackage

// File: rtl/stereo_rx_sync.sv
module stereo_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stereo_rx_align.sv
module stereo_rx_align
  import stereo_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic fs,
  input  logic sdat,
  input  fmt_e mode_req,
  output logic bit_stb,
  output logic bit_first,
  output logic bit_left,
  output logic bit_val,
  output logic sw_edge
);
  logic bclk_q;
  logic fs_d;
  logic fs_seen;
  logic eff_q;
  logic eff_seen;
  fmt_e act_q;
  fmt_e mode_now;
  logic edge_w;
  logic fs_rise;
  logic eff;
  logic eff_ok;

  assign edge_w   = bclk & ~bclk_q;
  // a frame starts when frame sync rises between two sampled edges
  assign fs_rise  = edge_w & fs_seen & fs & ~fs_d;
  assign mode_now = fs_rise ? mode_req : act_q;

  // effective frame sync: delayed by one bit edge in the delayed alignment
  always_comb begin
    if (mode_now == FMT_DELAY) begin
      eff    = fs_d;
      eff_ok = fs_seen;
    end else begin
      eff    = fs;
      eff_ok = 1'b1;
    end
  end

  assign bit_stb   = edge_w & eff_ok;
  assign bit_first = bit_stb & eff_seen & (eff ^ eff_q);
  assign bit_left  = eff;
  assign bit_val   = sdat;
  assign sw_edge   = fs_rise & (mode_req != act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q   <= 1'b0;
      fs_d     <= 1'b0;
      fs_seen  <= 1'b0;
      eff_q    <= 1'b0;
      eff_seen <= 1'b0;
      act_q    <= mode_req;
    end else begin
      bclk_q <= bclk;
      if (edge_w) begin
        fs_d    <= fs;
        fs_seen <= 1'b1;
        if (eff_ok) begin
          eff_q    <= eff;
          eff_seen <= 1'b1;
        end
        if (fs_rise) act_q <= mode_req;
      end
    end
  end
endmodule

// File: rtl/stereo_rx_deser.sv
module stereo_rx_deser #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_stb,
  input  logic         bit_first,
  input  logic         bit_left,
  input  logic         bit_val,
  input  logic         sw_edge,
  output logic         pair_valid,
  output logic [W-1:0] pair_l,
  output logic [W-1:0] pair_r,
  output logic         word_err
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [W-1:0]  sh;
  logic [W-1:0]  left_q;
  logic [CW-1:0] cnt;
  logic          chan_left;
  logic          left_have;
  logic          busy;
  logic [W-1:0]  word_nx;

  assign busy    = (cnt != '0) && (cnt != FULL);
  assign word_nx = {sh[W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh         <= '0;
      left_q     <= '0;
      cnt        <= '0;
      chan_left  <= 1'b0;
      left_have  <= 1'b0;
      pair_valid <= 1'b0;
      pair_l     <= '0;
      pair_r     <= '0;
      word_err   <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      word_err   <= 1'b0;
      if (bit_stb) begin
        if (bit_first) begin
          if (busy && !sw_edge) word_err <= 1'b1;
          sh        <= {{(W-1){1'b0}}, bit_val};
          cnt       <= ONE;
          chan_left <= bit_left;
          if (bit_left) left_have <= 1'b0;
        end else if (busy) begin
          sh  <= word_nx;
          cnt <= cnt + ONE;
          if (cnt == LAST) begin
            if (chan_left) begin
              left_q    <= word_nx;
              left_have <= 1'b1;
            end else if (left_have) begin
              pair_l     <= left_q;
              pair_r     <= word_nx;
              pair_valid <= 1'b1;
              left_have  <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/stereo_rx.sv
module stereo_rx
  import stereo_rx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i2s,
  input  logic              ser_bclk,
  input  logic              ser_fs,
  input  logic              ser_dat,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right,
  output logic              out_err
);
  logic [2:0] ser_s;
  logic bit_stb, bit_first, bit_left, bit_val, sw_edge;
  fmt_e mode_req;

  assign mode_req = fmt_e'(mode_i2s);

  stereo_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_bclk, ser_fs, ser_dat}),
    .q   (ser_s)
  );

  stereo_rx_align u_align (
    .clk       (clk),
    .rst       (rst),
    .bclk      (ser_s[2]),
    .fs        (ser_s[1]),
    .sdat      (ser_s[0]),
    .mode_req  (mode_req),
    .bit_stb   (bit_stb),
    .bit_first (bit_first),
    .bit_left  (bit_left),
    .bit_val   (bit_val),
    .sw_edge   (sw_edge)
  );

  stereo_rx_deser #(.W(WORD_W)) u_deser (
    .clk        (clk),
    .rst        (rst),
    .bit_stb    (bit_stb),
    .bit_first  (bit_first),
    .bit_left   (bit_left),
    .bit_val    (bit_val),
    .sw_edge    (sw_edge),
    .pair_valid (out_valid),
    .pair_l     (out_left),
    .pair_r     (out_right),
    .word_err   (out_err)
  );
endmodule

// File: rtl/stereo_rx_chk.sv
module stereo_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         out_valid,
  input logic         out_err,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right
);
  // R1: outputs quiet right after a reset cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && out_left == '0 && out_right == '0));

  // R4: pair strobe lasts one cycle
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4: pair outputs move only with the strobe
  a_r4_pair_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));

  // R6: error strobe lasts one cycle
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (rst)
    out_err |=> !out_err);

  // R6: error and pair never coincide
  a_r6_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(out_err && out_valid));
endmodule

bind stereo_rx stereo_rx_chk #(.W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_err   (out_err),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/stereo_rx_test.sv
module stereo_rx_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;
  localparam int MAXP  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_i2s = 1'b0;
  logic bclk = 1'b0;
  logic fs = 1'b0;
  logic sd = 1'b0;
  logic        out_valid, out_err;
  logic [15:0] out_left, out_right;

  int n_chk = 0;
  int n_fail = 0;
  int n_pairs = 0;
  int n_err = 0;
  int exp_n = 0;
  logic [15:0] got_l [MAXP];
  logic [15:0] got_r [MAXP];
  logic [15:0] exp_l [MAXP];
  logic [15:0] exp_r [MAXP];
  logic carry = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stereo_rx uut (
    .clk(clk), .rst(rst), .mode_i2s(mode_i2s),
    .ser_bclk(bclk), .ser_fs(fs), .ser_dat(sd),
    .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .out_err(out_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (n_pairs < MAXP) begin
          got_l[n_pairs] = out_left;
          got_r[n_pairs] = out_right;
        end
        n_pairs++;
      end
      if (out_err) n_err++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic period(input logic f, input logic b);
    @(negedge clk);
    bclk = 1'b0; fs = f; sd = b;
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_phase(input logic f, input logic [15:0] w, input int nbits, input logic dly);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      if (!dly) b = (i < 16) ? w[15-i] : 1'b1;
      else      b = (i == 0) ? carry : ((i < 16) ? w[16-i] : 1'b0);
      period(f, b);
    end
    if (dly && nbits >= 16) carry = w[0];
  endtask

  task automatic send_pair(input logic [15:0] l, input logic [15:0] r, input logic dly,
                           input int nl, input int nr);
    send_phase(1'b1, l, nl, dly);
    send_phase(1'b0, r, nr, dly);
  endtask

  task automatic expect_pair(input logic [15:0] l, input logic [15:0] r);
    exp_l[exp_n] = l;
    exp_r[exp_n] = r;
    exp_n++;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic compare(input string req, input int from);
    chk({req, " pair count"}, n_pairs, exp_n);
    for (int i = from; i < exp_n && i < n_pairs; i++) begin
      chk({req, " left"}, got_l[i], exp_l[i]);
      chk({req, " right"}, got_r[i], exp_r[i]);
    end
  endtask

  function automatic logic [15:0] lval(input int k);
    if (k == 0) return 16'h8000;
    if (k == 1) return 16'h0000;
    return 16'(k * 2731 + 1);
  endfunction

  function automatic logic [15:0] rval(input int k);
    if (k == 0) return 16'h7FFF;
    if (k == 1) return 16'hFFFF;
    return 16'(~(k * 4099));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    int err_base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 valid", out_valid, 0);
    chk("R1 err", out_err, 0);
    chk("R1 left", out_left, 0);
    chk("R1 right", out_right, 0);

    // R8: partial phase after reset, then a lone right word
    for (int i = 0; i < 5; i++) period(1'b1, 1'b1);
    send_phase(1'b0, 16'hAAAA, 16, 1'b0);
    settle();
    chk("R8 no pair", n_pairs, 0);
    chk("R8 no err", n_err, 0);

    // R2 R4: justified sweep
    base = exp_n;
    for (int k = 0; k < 24; k++) begin
      send_pair(lval(k), rval(k), 1'b0, 16, 16);
      expect_pair(lval(k), rval(k));
    end
    settle();
    compare("R2 R4", base);
    chk("R4 hold left", out_left, lval(23));
    chk("R4 hold right", out_right, rval(23));
    chk("R2 no err", n_err, 0);

    // R5: overlong phases
    base = exp_n;
    send_pair(16'h1357, 16'hFEDC, 1'b0, 19, 18);
    expect_pair(16'h1357, 16'hFEDC);
    settle();
    compare("R5", base);

    // R6: short left, short right, then recovery
    base = exp_n;
    err_base = n_err;
    send_pair(16'h4444, 16'h5555, 1'b0, 10, 16);
    settle();
    chk("R6 short left err", n_err, err_base + 1);
    chk("R6 short left no pair", n_pairs, exp_n);
    send_pair(16'h6666, 16'h7777, 1'b0, 16, 9);
    send_pair(16'h0F0F, 16'hF0F0, 1'b0, 16, 16);
    expect_pair(16'h0F0F, 16'hF0F0);
    settle();
    chk("R6 short right err", n_err, err_base + 2);
    compare("R6 recovery", base);

    // R7: request delayed alignment mid-frame; this frame stays justified
    base = exp_n;
    err_base = n_err;
    send_phase(1'b1, 16'h2468, 16, 1'b0);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] rw;
      rw = 16'hACE1;
      period(1'b0, rw[15-i]);
      if (i == 7) mode_i2s = 1'b1;
    end
    expect_pair(16'h2468, 16'hACE1);
    // R3: delayed sweep; the last pair is cut by the switch back
    carry = 1'b0;
    for (int k = 0; k < 16; k++) begin
      send_pair(lval(k + 3), rval(k + 5), 1'b1, 16, 16);
      if (k < 15) expect_pair(lval(k + 3), rval(k + 5));
    end
    mode_i2s = 1'b0;
    for (int k = 0; k < 4; k++) begin
      send_pair(rval(k + 40), lval(k + 40), 1'b0, 16, 16);
      expect_pair(rval(k + 40), lval(k + 40));
    end
    settle();
    compare("R3 R7", base);
    chk("R7 switch no err", n_err, err_base);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_fail);
    $finish;
  end
endmodule